// File: doc/BRIEF.md
# Automatic Receive-Threshold Flow-Control Character Generator

This block sits beside a UART transmitter and takes over its byte input when the local receive FIFO is filling up or draining. It compares the FIFO fill count against two thresholds, an upper one and a lower one. When the count goes above the upper threshold, it asks the transmitter to send the stop character or characters. When the count then falls below the lower threshold, it asks for the resume character or characters. The gap between the two thresholds gives hysteresis, so the block does not chatter while the level sits between them.

A "remote stopped" flag records which message was sent last. Because of that flag, each crossing produces exactly one sequence. A sequence is either one character or two, chosen by a mode input. The transmitter gives these bytes priority over user data. It accepts a byte by raising `fc_ack` only at a character boundary. If the level moves back across the threshold before the first byte is accepted, the pending request is withdrawn and nothing is sent.

The FSM has five states:
- `ST_IDLE`: no request.
- `ST_XOFF_A` and `ST_XOFF_B`: first and second stop byte.
- `ST_XON_A` and `ST_XON_B`: first and second resume byte.

The FSM has these transitions:
- *start-stop*: IDLE to XOFF_A.
- *start-resume*: IDLE to XON_A.
- *cancel*: an A state back to IDLE.
- *advance*: an A state to a B state, in two-byte mode.
- *finish*: the last byte is accepted, the FSM returns to IDLE and the flag is updated.
- *abort*: enable is low, every state goes to IDLE.

Top module: `flowctl_tx_gen`

## Requirements
- R1: After reset `fc_req` is low, the FSM is in ST_IDLE and the remote is treated as running (not stopped).
- R2: With `enable` high, the remote running and `rx_level > trig_hi`, `fc_req` rises one clock later with `fc_data = xoff1`.
- R3: In single mode (`double_mode = 0`), accepting the stop byte marks the remote stopped. No further stop request is made while the flag is set, even if the level stays high.
- R4: With `double_mode = 1` at the first acceptance, the cycle after that acceptance requests the second byte (`xoff2` or `xon2`). The flag updates only when that second byte is accepted. The mode is sampled at the first acceptance.
- R5: With the remote stopped and `rx_level < trig_lo`, `fc_req` rises one clock later with `fc_data = xon1`. Accepting the last resume byte marks the remote running.
- R6: A level with `trig_lo <= rx_level <= trig_hi` starts no sequence.
- R7: While the first byte waits, if the threshold condition stops holding, `fc_req` drops in that same cycle and the FSM returns to ST_IDLE. Nothing is sent and the flag is unchanged.
- R8: Once the first byte of a two-byte sequence is accepted, the second byte is requested regardless of the level.
- R9: A transfer happens only when `fc_req` and `fc_ack` are both high. A held request keeps the same byte until it is accepted, and `fc_ack` without `fc_req` has no effect.
- R10: With `enable` low, `fc_req` is low in that same cycle. At the next clock the sequence is abandoned and the remote is treated as running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Automatic flow-control enable |
| double_mode | input | 1 | 1: two-character sequences, 0: one character |
| rx_level | input | LEVEL_W | Receive FIFO fill count |
| trig_hi | input | LEVEL_W | Upper threshold (stop above it) |
| trig_lo | input | LEVEL_W | Lower threshold (resume below it) |
| xon1 | input | CHAR_W | First resume character |
| xon2 | input | CHAR_W | Second resume character |
| xoff1 | input | CHAR_W | First stop character |
| xoff2 | input | CHAR_W | Second stop character |
| fc_ack | input | 1 | Transmitter takes the offered byte at a character boundary |
| fc_req | output | 1 | Flow-control byte offered |
| fc_data | output | CHAR_W | Byte offered |

## Verification
`fc_req` and `fc_data` are combinational from the FSM state and the current inputs. A cancellation or a disable therefore shows in the same cycle as its cause. A new request starts one clock after the level crosses a threshold, and each acceptance moves the state one clock later. The bench drives inputs on the falling edge and samples one time unit later, before the rising edge. It then advances its own reference state on that rising edge, so every expectation matches the cycle the requirement names.

// File: rtl/fc_pkg.sv
package fc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_XOFF_A = 3'd1,
        ST_XOFF_B = 3'd2,
        ST_XON_A  = 3'd3,
        ST_XON_B  = 3'd4
    } fc_state_e;
endpackage

// File: rtl/fc_level_watch.sv
module fc_level_watch #(
    parameter int LEVEL_W = 7
) (
    input  logic               enable,
    input  logic [LEVEL_W-1:0] level,
    input  logic [LEVEL_W-1:0] trig_hi,
    input  logic [LEVEL_W-1:0] trig_lo,
    output logic               want_xoff,
    output logic               want_xon
);
    always_comb begin
        want_xoff = enable && (level > trig_hi);
        want_xon  = enable && (level < trig_lo);
    end
endmodule

// File: rtl/fc_char_pick.sv
module fc_char_pick
    import fc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  fc_state_e          state,
    input  logic [CHAR_W-1:0]  xon1,
    input  logic [CHAR_W-1:0]  xon2,
    input  logic [CHAR_W-1:0]  xoff1,
    input  logic [CHAR_W-1:0]  xoff2,
    output logic [CHAR_W-1:0]  data
);
    always_comb begin
        unique case (state)
            ST_XOFF_A: data = xoff1;
            ST_XOFF_B: data = xoff2;
            ST_XON_A:  data = xon1;
            ST_XON_B:  data = xon2;
            default:   data = '0;
        endcase
    end
endmodule

// File: rtl/flowctl_tx_gen.sv
module flowctl_tx_gen
    import fc_pkg::*;
#(
    parameter int LEVEL_W = 7,
    parameter int CHAR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               double_mode,
    input  logic [LEVEL_W-1:0] rx_level,
    input  logic [LEVEL_W-1:0] trig_hi,
    input  logic [LEVEL_W-1:0] trig_lo,
    input  logic [CHAR_W-1:0]  xon1,
    input  logic [CHAR_W-1:0]  xon2,
    input  logic [CHAR_W-1:0]  xoff1,
    input  logic [CHAR_W-1:0]  xoff2,
    input  logic               fc_ack,
    output logic               fc_req,
    output logic [CHAR_W-1:0]  fc_data
);
    fc_state_e state_q, state_d;
    logic      stopped_q, stopped_d;
    logic      want_xoff, want_xon;
    logic      xfer;

    fc_level_watch #(.LEVEL_W(LEVEL_W)) u_watch (
        .enable    (enable),
        .level     (rx_level),
        .trig_hi   (trig_hi),
        .trig_lo   (trig_lo),
        .want_xoff (want_xoff),
        .want_xon  (want_xon)
    );

    fc_char_pick #(.CHAR_W(CHAR_W)) u_pick (
        .state (state_q),
        .xon1  (xon1),
        .xon2  (xon2),
        .xoff1 (xoff1),
        .xoff2 (xoff2),
        .data  (fc_data)
    );

    // Output process: the first byte is offered only while its condition holds
    always_comb begin
        unique case (state_q)
            ST_XOFF_A:           fc_req = want_xoff;
            ST_XON_A:            fc_req = want_xon;
            ST_XOFF_B, ST_XON_B: fc_req = enable;
            default:             fc_req = 1'b0;
        endcase
    end

    assign xfer = fc_req && fc_ack;

    // Next-state logic
    always_comb begin
        state_d   = state_q;
        stopped_d = stopped_q;
        if (!enable) begin
            state_d   = ST_IDLE;
            stopped_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (!stopped_q && want_xoff)     state_d = ST_XOFF_A;
                    else if (stopped_q && want_xon)  state_d = ST_XON_A;
                end
                ST_XOFF_A: begin
                    if (!want_xoff) begin
                        state_d = ST_IDLE;
                    end else if (xfer) begin
                        if (double_mode) begin
                            state_d = ST_XOFF_B;
                        end else begin
                            state_d   = ST_IDLE;
                            stopped_d = 1'b1;
                        end
                    end
                end
                ST_XOFF_B: begin
                    if (xfer) begin
                        state_d   = ST_IDLE;
                        stopped_d = 1'b1;
                    end
                end
                ST_XON_A: begin
                    if (!want_xon) begin
                        state_d = ST_IDLE;
                    end else if (xfer) begin
                        if (double_mode) begin
                            state_d = ST_XON_B;
                        end else begin
                            state_d   = ST_IDLE;
                            stopped_d = 1'b0;
                        end
                    end
                end
                ST_XON_B: begin
                    if (xfer) begin
                        state_d   = ST_IDLE;
                        stopped_d = 1'b0;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            stopped_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            stopped_q <= stopped_d;
        end
    end
endmodule

// File: rtl/fc_tx_checker.sv
module fc_tx_checker
    import fc_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      enable,
    input logic      double_mode,
    input logic      fc_req,
    input logic      fc_ack,
    input fc_state_e state,
    input logic      stopped
);
    // R10
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fc_req |-> enable);

    // R4
    xoff_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XOFF_A && fc_req && fc_ack && double_mode) |=> (state == ST_XOFF_B));

    // R3
    stop_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> $past(fc_req && fc_ack));

    // R5
    stop_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stopped) |-> ($past(fc_req && fc_ack) || !$past(enable)));

    // R3
    stopped_no_xoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |-> !(state == ST_XOFF_A || state == ST_XOFF_B));

    // R9
    second_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_req && !fc_ack && (state == ST_XOFF_B || state == ST_XON_B)) |=> $stable(state));
endmodule

bind flowctl_tx_gen fc_tx_checker u_fc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (enable),
    .double_mode (double_mode),
    .fc_req      (fc_req),
    .fc_ack      (fc_ack),
    .state       (state_q),
    .stopped     (stopped_q)
);

// File: tb/test_flowctl_tx_gen.sv
module test_flowctl_tx_gen;
    localparam int CLK_PERIOD = 10;
    localparam int LW = 7;
    localparam int CW = 8;
    localparam int RAND_CYCLES = 4000;
    localparam int WATCHDOG = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0, dbl = 1'b0, ack = 1'b0;
    logic [LW-1:0] lvl = '0, hi = 7'd40, lo = 7'd10;
    logic [CW-1:0] xon1 = 8'h11, xon2 = 8'h51, xoff1 = 8'h13, xoff2 = 8'h93;
    logic          fc_req;
    logic [CW-1:0] fc_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state: 0 idle, 1 stop-a, 2 stop-b, 3 resume-a, 4 resume-b
    int m_phase = 0;
    bit m_stop  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flowctl_tx_gen #(.LEVEL_W(LW), .CHAR_W(CW)) i_flowctl_tx_gen (
        .clk(clk), .rst_n(rst_n), .enable(en), .double_mode(dbl),
        .rx_level(lvl), .trig_hi(hi), .trig_lo(lo),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
        .fc_ack(ack), .fc_req(fc_req), .fc_data(fc_data)
    );

    function automatic bit exp_req();
        bit n_off = en && (lvl > hi);
        bit n_on  = en && (lvl < lo);
        case (m_phase)
            1: return n_off;
            3: return n_on;
            2, 4: return en;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [CW-1:0] exp_data();
        case (m_phase)
            1: return xoff1;
            2: return xoff2;
            3: return xon1;
            4: return xon2;
            default: return '0;
        endcase
    endfunction

    task automatic model_step();
        bit n_off = en && (lvl > hi);
        bit n_on  = en && (lvl < lo);
        bit x = exp_req() && ack;
        if (!en) begin
            m_phase = 0; m_stop = 0;
        end else begin
            case (m_phase)
                0: if (!m_stop && n_off) m_phase = 1;
                   else if (m_stop && n_on) m_phase = 3;
                1: if (!n_off) m_phase = 0;
                   else if (x) begin
                       if (dbl) m_phase = 2; else begin m_phase = 0; m_stop = 1; end
                   end
                2: if (x) begin m_phase = 0; m_stop = 1; end
                3: if (!n_on) m_phase = 0;
                   else if (x) begin
                       if (dbl) m_phase = 4; else begin m_phase = 0; m_stop = 0; end
                   end
                4: if (x) begin m_phase = 0; m_stop = 0; end
                default: m_phase = 0;
            endcase
        end
    endtask

    task automatic compare(input string tag, input bit er, input logic [CW-1:0] ed);
        checks++;
        if (fc_req !== er) begin
            errors++;
            $display("FAIL %s: fc_req actual %b expected %b", tag, fc_req, er);
        end else if (er && fc_data !== ed) begin
            errors++;
            $display("FAIL %s: fc_data actual %h expected %h", tag, fc_data, ed);
        end
    endtask

    // called at a falling edge with inputs set; checks, then advances one clock
    task automatic cyc(input string tag, input bit use_exp, input bit er, input logic [CW-1:0] ed);
        #1;
        if (use_exp) compare(tag, er, ed);
        else         compare(tag, exp_req(), exp_data());
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(negedge clk);
        #1;
        compare("R1", 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        en = 1; dbl = 0; ack = 0;

        lvl = 7'd20;                    cyc("R6", 1, 0, '0);
        lvl = 7'd40;                    cyc("R6", 1, 0, '0);
        lvl = 7'd41;                    cyc("R2", 1, 0, '0);
                                        cyc("R2", 1, 1, 8'h13);
                                        cyc("R9", 1, 1, 8'h13);
        ack = 1;                        cyc("R3", 1, 1, 8'h13);
        ack = 0;                        cyc("R3", 1, 0, '0);
        ack = 1;                        cyc("R9", 1, 0, '0);
        ack = 0; lvl = 7'd25;           cyc("R6", 1, 0, '0);
        lvl = 7'd9;                     cyc("R5", 1, 0, '0);
                                        cyc("R5", 1, 1, 8'h11);
        lvl = 7'd12;                    cyc("R7", 1, 0, '0);
                                        cyc("R7", 1, 0, '0);
        lvl = 7'd5;                     cyc("R5", 1, 0, '0);
        dbl = 1; ack = 1;               cyc("R4", 1, 1, 8'h11);
        ack = 0; lvl = 7'd50;           cyc("R8", 1, 1, 8'h51);
        ack = 1;                        cyc("R8", 1, 1, 8'h51);
        ack = 0;                        cyc("R5", 1, 0, '0);
        ack = 1;                        cyc("R2", 1, 1, 8'h13);
        ack = 0;                        cyc("R4", 1, 1, 8'h93);
        en = 0;                         cyc("R10", 1, 0, '0);
        en = 1;                         cyc("R10", 1, 0, '0);
                                        cyc("R10", 1, 1, 8'h13);

        for (int i = 0; i < RAND_CYCLES; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 3) begin
                lvl = LW'($urandom_range(0, 64));
            end else if (r < 60) begin
                if ($urandom_range(0, 1) == 1 && lvl < 7'd64) lvl = lvl + 1'b1;
                else if (lvl > 0) lvl = lvl - 1'b1;
            end
            ack = ($urandom_range(0, 1) == 1);
            if ($urandom_range(0, 49) == 0) dbl = ~dbl;
            en = ($urandom_range(0, 99) != 0);
            if ($urandom_range(0, 499) == 0) begin
                hi = LW'($urandom_range(30, 60));
                lo = LW'($urandom_range(2, 25));
            end
            case (m_phase)
                1, 2: cyc("R2/R4 random stop", 0, 0, '0);
                3, 4: cyc("R5/R8 random resume", 0, 0, '0);
                default: cyc("R6/R7 random idle", 0, 0, '0);
            endcase
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule